// File: doc/BRIEF.md
# Hierarchical Crosswise-Column 24x24 Unsigned Multiplier

This block multiplies two unsigned 24-bit operands into a 48-bit product, such as the significand product of a single-precision floating-point multiplier. It is built as a three-level tree, with no array, Booth or behavioural multiplier anywhere in it. At the bottom sits a 4x4 leaf that uses the vertical-and-crosswise method. For each output column, the leaf adds up the AND products of every operand bit pair whose indices sum to that column, plus the carry left by the previous column. The low bit of that total becomes the product bit, and the rest of the total moves on as the next carry. The first column starts with a carry of zero.

Four leaves form an 8x8 unit, which joins the nibble cross products with three 8-bit ripple-carry adders. Nine 8x8 units form the 24x24 level. Each operand is split into three bytes, and the byte-pair products are grouped by weight 2^(8·(i+j)). Each group is summed with ripple-carry adders. The aligned group sums then pass through three full-width ripple-carry adders. Every adder is a chain of explicit full-adder instances.

The multiplier tree is purely combinational. By default an asynchronously reset register holds the result, so the product of the operands present at one rising edge appears after that edge.

Top module: `cwv_mul24`

## Requirements
- R1: With the default output register, `prod` equals the unsigned product `op_a`·`op_b` of the operands sampled at the previous rising edge, for any operand values.
- R2: While `rst_n` is low, `prod` is 0 whatever the operands are.
- R3: The 4x4 leaf is exact for all 256 pairs of 4-bit operands, tested by putting them in bits 3:0 of both inputs with all higher bits zero.
- R4: The 8x8 unit is exact for all 65536 pairs of 8-bit operands, tested by putting them in bits 7:0 of both inputs with all higher bits zero.
- R5: When either operand is zero, the product is zero.
- R6: When one operand is 1, the product equals the other operand, zero-extended to 48 bits.
- R7: Two all-ones operands (0xFFFFFF) give 0xFFFFFE000001, which needs carries through every byte group.
- R8: 0x800000 times 0x800000 gives 0x400000000000, and 0x800000 times 0xFFFFFF gives 0x7FFFFF800000.
- R9: A new operand pair is accepted on every clock, and back-to-back results do not depend on the previous pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset, clears the product register |
| op_a | input | 24 | Unsigned multiplicand |
| op_b | input | 24 | Unsigned multiplier |
| prod | output | 48 | Unsigned product |

## Verification
The hardest results to reach are the ones where carries leave the 4x4 leaves and byte units and ripple through the equal-weight group adders and all three alignment adders. A random operand pair only rarely drives those long chains. The stimulus therefore applies the all-ones and single-top-bit operands, which fill every partial product at once. It also sweeps all pairs exhaustively in the low nibble and the low byte, which covers every leaf column and every 8x8 combining path. Random pairs follow one another on consecutive clocks, so any dependence on the previous result would show up.

// File: rtl/cwv_mul_pkg.sv
package cwv_mul_pkg;
  localparam int OP_W   = 24;
  localparam int PROD_W = 2 * OP_W;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int NBYTE  = OP_W / BYTE_W;
  localparam int PP_W   = 2 * BYTE_W;
  localparam int LEAF_W = 2 * NIB_W;

  // Vertical-and-crosswise column evaluation of a 4x4 product.
  function automatic logic [LEAF_W-1:0] cw_leaf(input logic [NIB_W-1:0] x,
                                                input logic [NIB_W-1:0] y);
    logic [LEAF_W-1:0] r;
    logic [2:0] acc;
    logic [2:0] cy;
    r  = '0;
    cy = '0;
    for (int k = 0; k < LEAF_W - 1; k++) begin
      acc = cy;
      for (int i = 0; i < NIB_W; i++) begin
        int j;
        j = k - i;
        if (j >= 0 && j < NIB_W) acc = acc + {2'b00, x[i] & y[j]};
      end
      r[k] = acc[0];
      cy   = {1'b0, acc[2:1]};
    end
    r[LEAF_W-1] = cy[0];
    return r;
  endfunction
endpackage

// File: rtl/cwv_full_adder.sv
module cwv_full_adder (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  logic p;
  assign p  = a ^ b;
  assign s  = p ^ ci;
  assign co = (a & b) | (p & ci);
endmodule

// File: rtl/cwv_rca.sv
module cwv_rca #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] c;
  assign c[0] = cin;
  for (genvar i = 0; i < W; i++) begin : g_bit
    cwv_full_adder u_fa (
      .a (x[i]),
      .b (y[i]),
      .ci(c[i]),
      .s (sum[i]),
      .co(c[i+1])
    );
  end
  assign cout = c[W];
endmodule

// File: rtl/cwv_leaf4.sv
module cwv_leaf4
  import cwv_mul_pkg::*;
(
  input  logic [NIB_W-1:0]  x,
  input  logic [NIB_W-1:0]  y,
  output logic [LEAF_W-1:0] p
);
  assign p = cw_leaf(x, y);
endmodule

// File: rtl/cwv_mul8.sv
module cwv_mul8
  import cwv_mul_pkg::*;
(
  input  logic [BYTE_W-1:0] x,
  input  logic [BYTE_W-1:0] y,
  output logic [PP_W-1:0]   p,
  output logic [LEAF_W-1:0] dbg_leaf
);
  logic [LEAF_W-1:0] ll, hl, lh, hh;
  logic [BYTE_W-1:0] mid_s, up_s, top_s;
  logic mid_c, up_c, unused_top_c;
  logic [3:0] unused_top_hi;

  cwv_leaf4 u_ll (.x(x[NIB_W-1:0]),      .y(y[NIB_W-1:0]),      .p(ll));
  cwv_leaf4 u_hl (.x(x[BYTE_W-1:NIB_W]), .y(y[NIB_W-1:0]),      .p(hl));
  cwv_leaf4 u_lh (.x(x[NIB_W-1:0]),      .y(y[BYTE_W-1:NIB_W]), .p(lh));
  cwv_leaf4 u_hh (.x(x[BYTE_W-1:NIB_W]), .y(y[BYTE_W-1:NIB_W]), .p(hh));

  // cross terms of equal weight
  cwv_rca #(.W(BYTE_W)) u_mid (.x(hl), .y(lh), .cin(1'b0), .sum(mid_s), .cout(mid_c));
  // bits 11:4
  cwv_rca #(.W(BYTE_W)) u_up (
    .x({hh[NIB_W-1:0], ll[LEAF_W-1:NIB_W]}), .y(mid_s), .cin(1'b0),
    .sum(up_s), .cout(up_c));
  // bits 15:12
  cwv_rca #(.W(BYTE_W)) u_top (
    .x({4'b0000, hh[LEAF_W-1:NIB_W]}), .y({7'b0, mid_c}), .cin(up_c),
    .sum(top_s), .cout(unused_top_c));

  assign unused_top_hi = top_s[BYTE_W-1:NIB_W];
  assign p        = {top_s[NIB_W-1:0], up_s, ll[NIB_W-1:0]};
  assign dbg_leaf = ll;
endmodule

// File: rtl/cwv_mul24_core.sv
module cwv_mul24_core
  import cwv_mul_pkg::*;
(
  input  logic [OP_W-1:0]   a,
  input  logic [OP_W-1:0]   b,
  output logic [PROD_W-1:0] p,
  output logic [PP_W-1:0]   dbg_byte_prod,
  output logic [LEAF_W-1:0] dbg_leaf_prod
);
  logic [PP_W-1:0]   pp   [NBYTE][NBYTE];
  logic [LEAF_W-1:0] leaf [NBYTE][NBYTE];

  for (genvar i = 0; i < NBYTE; i++) begin : g_ai
    for (genvar j = 0; j < NBYTE; j++) begin : g_bj
      cwv_mul8 u_m8 (
        .x(a[i*BYTE_W +: BYTE_W]),
        .y(b[j*BYTE_W +: BYTE_W]),
        .p(pp[i][j]),
        .dbg_leaf(leaf[i][j])
      );
    end
  end

  // equal-weight group sums
  logic [PP_W-1:0] g1_s, g2a_s, g4_s;
  logic            g1_c, g2a_c, g4_c;
  logic [PP_W:0]   g2_s;
  logic            g2_c;
  cwv_rca #(.W(PP_W)) u_g1  (.x(pp[0][1]), .y(pp[1][0]), .cin(1'b0), .sum(g1_s),  .cout(g1_c));
  cwv_rca #(.W(PP_W)) u_g2a (.x(pp[0][2]), .y(pp[1][1]), .cin(1'b0), .sum(g2a_s), .cout(g2a_c));
  cwv_rca #(.W(PP_W+1)) u_g2b (.x({g2a_c, g2a_s}), .y({1'b0, pp[2][0]}), .cin(1'b0),
                               .sum(g2_s), .cout(g2_c));
  cwv_rca #(.W(PP_W)) u_g3  (.x(pp[1][2]), .y(pp[2][1]), .cin(1'b0), .sum(g4_s),  .cout(g4_c));

  // aligned rows
  logic [PROD_W-1:0] row_e, row_1, row_2, row_3, acc1, acc2, acc3;
  logic unused_c1, unused_c2, unused_c3;
  assign row_e = {pp[2][2], {PP_W{1'b0}}, pp[0][0]};
  assign row_1 = {23'b0, g1_c, g1_s, 8'b0};
  assign row_2 = {14'b0, g2_c, g2_s, 16'b0};
  assign row_3 = {7'b0, g4_c, g4_s, 24'b0};

  cwv_rca #(.W(PROD_W)) u_f1 (.x(row_e), .y(row_1), .cin(1'b0), .sum(acc1), .cout(unused_c1));
  cwv_rca #(.W(PROD_W)) u_f2 (.x(acc1),  .y(row_2), .cin(1'b0), .sum(acc2), .cout(unused_c2));
  cwv_rca #(.W(PROD_W)) u_f3 (.x(acc2),  .y(row_3), .cin(1'b0), .sum(acc3), .cout(unused_c3));

  assign p             = acc3;
  assign dbg_byte_prod = pp[0][0];
  assign dbg_leaf_prod = leaf[0][0];
endmodule

// File: rtl/cwv_mul24.sv
module cwv_mul24
  import cwv_mul_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  output logic [PROD_W-1:0] prod
);
  logic [PROD_W-1:0] comb_prod;
  logic [PP_W-1:0]   dbg_byte_prod;
  logic [LEAF_W-1:0] dbg_leaf_prod;

  cwv_mul24_core u_core (
    .a(op_a),
    .b(op_b),
    .p(comb_prod),
    .dbg_byte_prod(dbg_byte_prod),
    .dbg_leaf_prod(dbg_leaf_prod)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prod <= '0;
      else        prod <= comb_prod;
    end
  end else begin : g_comb
    assign prod = comb_prod;
  end
endmodule

// File: rtl/cwv_mul24_chk.sv
module cwv_mul24_chk
  import cwv_mul_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [OP_W-1:0]   op_a,
  input logic [OP_W-1:0]   op_b,
  input logic [PROD_W-1:0] prod,
  input logic [PP_W-1:0]   byte_prod,
  input logic [LEAF_W-1:0] leaf_prod
);
  // R3
  leaf_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    leaf_prod == ({4'b0, op_a[3:0]} * {4'b0, op_b[3:0]}));
  // R4
  byte_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_prod == ({8'b0, op_a[7:0]} * {8'b0, op_b[7:0]}));

  if (OUT_REG) begin : g_reg_props
    // R1
    full_prod_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> prod == ($past({24'b0, op_a}) * $past({24'b0, op_b})));
    // R5
    zero_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_a == '0 || op_b == '0) |=> prod == '0);
    // R6
    unit_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_a == 24'd1) |=> prod == {24'b0, $past(op_b)});
  end
endmodule

bind cwv_mul24 cwv_mul24_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .op_a(op_a),
  .op_b(op_b),
  .prod(prod),
  .byte_prod(dbg_byte_prod),
  .leaf_prod(dbg_leaf_prod)
);

// File: tb/sim_cwv_mul24.sv
module sim_cwv_mul24;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] op_a = '0;
  logic [23:0] op_b = '0;
  logic [47:0] prod;
  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  cwv_mul24 u0 (.clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .prod(prod));

  // shift-and-add reference
  function automatic logic [47:0] ref_mul(input logic [23:0] x, input logic [23:0] y);
    longint unsigned acc = 0;
    for (int i = 0; i < 24; i++)
      if (y[i]) acc = acc + (longint'(x) << i);
    return acc[47:0];
  endfunction

  task automatic check(input logic [47:0] got, input logic [47:0] exp, input string req,
                       input logic [23:0] x, input logic [23:0] y);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h actual=%h expected=%h", req, x, y, got, exp);
    end
  endtask

  // drive at a falling edge, result is registered at the rising edge, sampled at the next falling edge
  task automatic apply(input logic [23:0] x, input logic [23:0] y, input string req);
    op_a = x;
    op_b = y;
    @(negedge clk);
    check(prod, ref_mul(x, y), req, x, y);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R2: reset holds zero
    op_a = 24'hFFFFFF;
    op_b = 24'hABCDEF;
    repeat (3) @(negedge clk);
    check(prod, 48'h0, "R2", op_a, op_b);
    rst_n = 1'b1;

    // R3: exhaustive 4x4 leaf
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        apply(24'(i), 24'(j), "R3");

    // R4: exhaustive 8x8 unit
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 256; j++)
        apply(24'(i), 24'(j), "R4");

    // R5: zero operand
    apply(24'h0, 24'hFFFFFF, "R5");
    apply(24'h9A5C31, 24'h0, "R5");
    // R6: unit operand
    apply(24'h1, 24'hFEDCBA, "R6");
    apply(24'h7F00FF, 24'h1, "R6");
    // R7: all ones
    apply(24'hFFFFFF, 24'hFFFFFF, "R7");
    check(prod, 48'hFFFFFE000001, "R7", op_a, op_b);
    // R8: top bit operands
    apply(24'h800000, 24'h800000, "R8");
    check(prod, 48'h400000000000, "R8", op_a, op_b);
    apply(24'h800000, 24'hFFFFFF, "R8");
    check(prod, 48'h7FFFFF800000, "R8", op_a, op_b);

    // R9: alternating extremes on consecutive clocks
    for (int k = 0; k < 8; k++) begin
      apply(24'hFFFFFF, 24'hFFFFFF, "R9");
      apply(24'h000001, 24'h000000, "R9");
      apply(24'h800001, 24'h00FF00, "R9");
    end

    // R1: random operands back to back
    for (int k = 0; k < 3000; k++)
      apply(24'($urandom), 24'($urandom), "R1");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule